// File: doc/BRIEF.md
# Population Count Divisibility Detector

This block looks at a vector of single-bit flags and raises one output when the number of set flags is an exact multiple of a chosen modulus K. Zero set flags counts as a multiple. The logic is purely combinational. Its datapath uses only NOT and two-input AND, OR and XOR operations. It never forms a binary count of the set bits.

The flags pass through a chain of folding cells. Each cell takes K single-bit lanes and returns K-1 lanes, and the number of high lanes modulo K stays the same. Inside a cell, a row of compare-swap elements pushes a low lane, when one exists, into the last slot, and that slot is then dropped. When every one of the K lanes is high, the cell clears all K-1 of its outputs, because K high lanes leave a remainder of zero. After N-K+1 cells, K-1 lanes remain. A NOR over those lanes gives the answer. When the vector is narrower than K, the only multiple that can occur is zero, so the block is just a NOR over the whole vector.

Each cell costs 3K-2 gates, so the chained form costs (N-K+1)(3K-2)+K-1 gates. The parameters are checked when the design is elaborated: K must be at least 2 and N must be at least 1.

Top module: `popdiv_detect`

## Requirements
- R1: `div_o` is 1 exactly when the number of 1 bits in `bits_i` is divisible by `K`, and 0 otherwise.
- R2: When `bits_i` is all zeros, `div_o` is 1.
- R3: When `N` is less than `K`, `div_o` is 1 only for the all-zero input and 0 for every other input.
- R4: A nonzero count that is a multiple of `K`, for example exactly `K` ones, drives `div_o` to 1.
- R5: A count whose remainder modulo `K` is `K-1` drives `div_o` to 0.
- R6: With `K` equal to 2, `div_o` is the even-parity flag of `bits_i`.
- R7: A folding cell with at least one low input drives as many high outputs as it has high inputs.
- R8: A folding cell whose `K` inputs are all high drives all `K-1` outputs low. When the lowest `K` bits of `bits_i` are all 1, the result is the same as for a vector with those bits cleared.
- R9: `div_o` depends only on how many bits are set, not on where they sit in `bits_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_i | input | N | Flags whose number of set bits is tested |
| div_o | output | 1 | High when the set-bit count is a multiple of K |

## Verification
A cell that miscounts, whether it drops a high lane or keeps a stale one, shifts the residue carried by every later cell. The error therefore reaches `div_o` in the same evaluation, for every input whose remaining bits do not happen to cancel it. Because the block has no state, a fault cannot stay hidden across cycles. Every input pattern of several small configurations is applied, so any wrong lane in any cell shows up as a wrong output for at least one pattern. Assertions inside each cell compare the lane counts before and after the cell, so a faulty cell is flagged where it sits rather than only at the output.

// File: rtl/popdiv_pkg.sv
// Shared helpers for the divisibility detector.
// Assumes: callers pass n >= 1 and k >= 2.
package popdiv_pkg;

    // Gate budget of one folding cell: compare-swap row, one inverter, output masks.
    function automatic int fold_cost(input int k);
        return 3 * k - 2;
    endfunction

    // Gate budget of the complete detector for the given sizes.
    function automatic int total_cost(input int n, input int k);
        if (n < k)
            return n;
        return (n - k + 1) * fold_cost(k) + k - 1;
    endfunction

endpackage

// File: rtl/pd_swap.sv
// Two-lane compare-swap element: the high lane leaves on hi_o, the low lane on lo_o.
// Assumes: single-bit lanes; the number of ones is preserved by construction.
module pd_swap (
    input  logic a_i,
    input  logic b_i,
    output logic hi_o,
    output logic lo_o
);

    // Ordering of two bits: OR gives the larger, AND the smaller.
    always_comb begin
        hi_o = a_i | b_i;
        lo_o = a_i & b_i;
    end

endmodule

// File: rtl/pd_nor.sv
// Wide NOR built as a chain of two-input ORs followed by one inverter.
// Assumes: W >= 1; uses W-1 OR gates plus one NOT.
module pd_nor #(
    parameter int W = 2
) (
    input  logic [W-1:0] lanes_i,
    output logic         none_o
);

    logic [W-1:0] acc;

    // First element of the OR chain.
    assign acc[0] = lanes_i[0];

    genvar g;
    generate
        for (g = 1; g < W; g++) begin : g_or
            // One two-input OR per additional lane.
            assign acc[g] = acc[g-1] | lanes_i[g];
        end
    endgenerate

    // Final inversion turns "any high" into "none high".
    assign none_o = ~acc[W-1];

endmodule

// File: rtl/pd_fold.sv
// Folding cell: K lanes in, K-1 lanes out, count of high lanes kept modulo K.
// A bubble pass of compare-swaps sinks a low lane (if any) into the discarded
// last slot; if all K lanes were high, every output is masked low.
// Assumes: K >= 2. Cost: 2K-2 swap gates, one NOT, K-1 ANDs.
module pd_fold #(
    parameter int K = 3
) (
    input  logic [K-1:0] lanes_i,
    output logic [K-2:0] lanes_o
);

    logic [K-1:0] sink;
    logic [K-2:0] pass;
    logic         keep_n;

    // Bubble pass starts from lane 0.
    assign sink[0] = lanes_i[0];

    genvar g;
    generate
        for (g = 1; g < K; g++) begin : g_pass
            pd_swap u_sw (
                .a_i  (sink[g-1]),
                .b_i  (lanes_i[g]),
                .hi_o (pass[g-1]),
                .lo_o (sink[g])
            );
        end
    endgenerate

    // Last slot is high only when all K inputs were high.
    assign keep_n = ~sink[K-1];

    generate
        for (g = 0; g < K - 1; g++) begin : g_mask
            // Clear surviving lanes when a full group of K was seen.
            assign lanes_o[g] = pass[g] & keep_n;
        end
    endgenerate

    // Guard: lane count kept when a low input exists, cleared on a full group.
    always_comb begin
        if (!$isunknown(lanes_i)) begin
            if (&lanes_i)
                p_full_clear_r8: assert (lanes_o == '0);
            else
                p_count_kept_r7: assert ($countones(lanes_o) == $countones(lanes_i));
        end
    end

endmodule

// File: rtl/popdiv_detect.sv
// Divisibility detector: div_o is high when the number of ones in bits_i
// is a multiple of K. Purely combinational, built only from NOT/AND/OR/XOR.
// Assumes: N >= 1, K >= 2 (checked at elaboration).
module popdiv_detect #(
    parameter int N = 8,
    parameter int K = 3
) (
    input  logic [N-1:0] bits_i,
    output logic         div_o
);

    import popdiv_pkg::*;

    localparam int FOLDS = (N >= K) ? (N - K + 1) : 0;
    localparam int GATES = total_cost(N, K);

    generate
        if (K < 2 || N < 1) begin : g_bad_params
            $error("popdiv_detect: need K >= 2 and N >= 1");
        end

        if (N < K) begin : g_narrow
            // Only a count of zero can be a multiple: plain NOR of all bits.
            pd_nor #(.W(N)) u_nor (
                .lanes_i (bits_i),
                .none_o  (div_o)
            );
        end else begin : g_chain
            logic [FOLDS:0][K-2:0] stage;

            // Seed the chain with the first K-1 input bits.
            assign stage[0] = bits_i[K-2:0];

            for (genvar j = 0; j < FOLDS; j++) begin : g_fold
                pd_fold #(.K(K)) u_fold (
                    .lanes_i ({bits_i[K-1+j], stage[j]}),
                    .lanes_o (stage[j+1])
                );
            end

            // Survivors all low means the residue is zero.
            pd_nor #(.W(K-1)) u_nor (
                .lanes_i (stage[FOLDS]),
                .none_o  (div_o)
            );
        end
    endgenerate

    // Guard: output agrees with popcount residue; the all-zero input is always divisible.
    always_comb begin
        if (!$isunknown(bits_i)) begin
            p_divisible_r1: assert (div_o == (($countones(bits_i) % K) == 0));
            if (bits_i == '0)
                p_zero_high_r2: assert (div_o == 1'b1);
        end
    end

endmodule

// File: tb/sim_popdiv_detect.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor pops and compares.
module sim_popdiv_detect;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic rst_n = 1'b0;

    logic [5:0] in0 = '0;   // N=6, K=3
    logic [1:0] in1 = '0;   // N=2, K=3 (narrow case)
    logic [6:0] in2 = '0;   // N=7, K=2
    logic [4:0] in3 = '0;   // N=5, K=5
    logic o0, o1, o2, o3;

    popdiv_detect #(.N(6), .K(3)) u0 (.bits_i(in0), .div_o(o0));
    popdiv_detect #(.N(2), .K(3)) u1 (.bits_i(in1), .div_o(o1));
    popdiv_detect #(.N(7), .K(2)) u2 (.bits_i(in2), .div_o(o2));
    popdiv_detect #(.N(5), .K(5)) u3 (.bits_i(in3), .div_o(o3));

    typedef struct {
        int     pat;
        logic   exp [4];
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    int widths [4] = '{6, 2, 7, 5};
    int mods   [4] = '{3, 3, 2, 5};

    function automatic int ones(input int v, input int w);
        int c = 0;
        for (int b = 0; b < w; b++) c += (v >> b) & 1;
        return c;
    endfunction

    // Tag each pattern with the requirement it exercises most directly.
    function automatic string tag_of(input int v, input int w, input int k);
        int c = ones(v, w);
        if (c == 0) return "R2";
        if (w < k) return "R3";
        if ((v & ((1 << k) - 1)) == ((1 << k) - 1)) return "R8";
        if (k == 2) return "R6";
        if (c % k == 0) return "R4";
        if (c % k == k - 1) return "R5";
        if (v & 1) return "R9";
        return "R7";
    endfunction

    // Driver: apply one pattern to all instances and queue the expectations.
    task automatic drive(input int p);
        item_t it;
        @(posedge clk);
        in0 <= p[5:0];
        in1 <= p[1:0];
        in2 <= p[6:0];
        in3 <= p[4:0];
        it.pat = p;
        for (int i = 0; i < 4; i++)
            it.exp[i] = ((ones(p & ((1 << widths[i]) - 1), widths[i]) % mods[i]) == 0);
        q.push_back(it);
    endtask

    // Monitor: on the falling edge, pop one item and compare every instance.
    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            logic got [4];
            it = q.pop_front();
            got[0] = o0; got[1] = o1; got[2] = o2; got[3] = o3;
            for (int i = 0; i < 4; i++) begin
                if (it.pat < (1 << widths[i])) begin
                    string t;
                    t = tag_of(it.pat, widths[i], mods[i]);
                    checks++;
                    if (got[i] !== it.exp[i]) begin
                        errors++;
                        $display("FAIL %s inst%0d pattern %0h actual %b expected %b",
                                 t, i, it.pat, got[i], it.exp[i]);
                    end
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n <= 1'b1;
        // Reset state: all-zero input on every instance must read divisible (R2).
        @(negedge clk);
        checks++;
        if ({o0, o1, o2, o3} !== 4'b1111) begin
            errors++;
            $display("FAIL R2 reset-state outputs actual %b expected 1111", {o0, o1, o2, o3});
        end
        // Exhaustive sweep: covers R1, R3-R9 across all four configurations.
        for (int p = 0; p < 128; p++) drive(p);
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule